// File: doc/BRIEF.md
# Four-Address I2C Slave Front End

This block sits on an I2C bus as a slave-only agent. It watches the open-drain clock and data lines, finds START and STOP conditions, and after each START shifts in the first byte. That byte is compared at the same time against four 8-bit identity registers. The comparison uses only the upper seven bits. On a hit, the block pulls SDA low for the acknowledge pulse. Bit 0 of the address byte then selects the direction: 0 selects receive and 1 selects transmit. On a miss, the block stays off the bus until the next START.

The block is a pure bus observer, so it runs independently of any master engine on the same chip. A local master that loses arbitration part-way through an address byte leaves this slave free to decode the same byte and answer it. The host loads the identity registers through a small write port. A write that arrives while a transfer is in progress is parked and takes effect once the bus goes idle. The host sees a match flag, the index of the matching register, a received-byte register with a valid strobe, and a transmit-byte input that is sampled at the start of each byte sent.

States: `SL_IDLE` (waiting for START), `SL_ADDR` (shifting the address), `SL_ADDR_ACK` (driving the address acknowledge), `SL_RX` / `SL_RX_ACK` (receiving a byte and acknowledging it), `SL_TX` / `SL_TX_ACK` (sending a byte and reading the master's acknowledge), and `SL_IGNORE` (addressed elsewhere).

Transitions:
- START moves any state to `SL_ADDR`.
- STOP moves any state to `SL_IDLE`.
- `SL_ADDR` goes to `SL_ADDR_ACK` on a hit or to `SL_IGNORE` on a miss, at the SCL fall after the eighth bit.
- `SL_ADDR_ACK` goes to `SL_RX` or `SL_TX` at the SCL fall that ends the ninth pulse.
- `SL_RX` goes to `SL_RX_ACK` after eight bits, and `SL_RX_ACK` returns to `SL_RX`.
- `SL_TX` goes to `SL_TX_ACK` after eight bits. `SL_TX_ACK` returns to `SL_TX` on an acknowledge, or goes to `SL_IDLE` on a not-acknowledge.

Top module: `i2c_quad_slave`

## Requirements
- R1: After reset `sda_oe`, `match`, `match_idx` and `rx_valid` are all 0, and all identity registers read as 0x00.
- R2: An address byte whose bits [7:1] equal bits [7:1] of any identity register is acknowledged. Acknowledging means `sda_oe` is 1 during the ninth SCL high period, and `match` is 1 from then on.
- R3: Bit 0 of each identity register takes no part in the comparison.
- R4: When several registers hit, `match_idx` reports the lowest index, and it holds steady while `match` is 1.
- R5: After an address miss, no later byte is acknowledged and `rx_valid` stays 0 until the next START.
- R6: With address bit 0 = 0, each following byte is acknowledged. It appears MSB-first in `rx_data`, with `rx_valid` pulsing for one clock.
- R7: With address bit 0 = 1, `tx_data` is sent MSB-first. It is sampled at the acknowledge fall and again after each master acknowledge.
- R8: In transmit, a master not-acknowledge (SDA high in the ninth pulse) releases SDA and clears `match` before any STOP.
- R9: An identity write made while the bus is idle takes effect at once. A write made between a START and a STOP, including across a repeated START, is held and applied after the STOP.
- R10: SDA is only ever pulled low (`sda_oe` = 1), and only while `match` is 1.
- R11: A START, including a repeated one, aborts any transfer, clears `match` and restarts address collection. A STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| id_wr_en | input | 1 | Host write strobe for identity registers |
| id_wr_idx | input | 2 | Identity register selected for write |
| id_wr_data | input | 8 | Identity value written |
| tx_data | input | 8 | Byte to send in transmit mode |
| match | output | 1 | Addressed and active in the current transfer |
| match_idx | output | 2 | Lowest-numbered identity register that matched |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-clock strobe when `rx_data` updates |

## Verification
A bit counter or state that slips by one shows up on the bus within the same byte. The acknowledge is missing during the ninth pulse, or a data bit is read shifted, so a fault is visible within nine SCL pulses of its cause. A wrong priority or comparison shows up in the `match_idx` and acknowledge sampled at the ninth pulse of one address sweep across all 128 addresses. A write that leaks into the bank mid-transfer appears as an acknowledge after a repeated START, where the old identity should still apply.

// File: rtl/i2c_qs_pkg.sv
package i2c_qs_pkg;
    typedef enum logic [2:0] {
        SL_IDLE,
        SL_ADDR,
        SL_ADDR_ACK,
        SL_RX,
        SL_RX_ACK,
        SL_TX,
        SL_TX_ACK,
        SL_IGNORE
    } sl_state_t;
endpackage

// File: rtl/i2c_qs_edge.sv
// Synchronises the bus lines and derives clock edges, START/STOP and bus-busy.
module i2c_qs_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic bus_busy
);
    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;
    logic                 scl_prev;
    logic                 sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_lvl  = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl  = sda_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bus_busy <= 1'b0;
        else if (start_evt) bus_busy <= 1'b1;
        else if (stop_evt)  bus_busy <= 1'b0;
    end
endmodule

// File: rtl/i2c_qs_idbank.sv
// Identity registers with deferred writes and a priority comparator.
module i2c_qs_idbank #(
    parameter int N_ID  = 4,
    parameter int IDX_W = $clog2(N_ID)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_busy,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        addr_byte,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [N_ID*8-1:0] ids_flat
);
    logic [N_ID-1:0] hit_vec;

    for (genvar g = 0; g < N_ID; g++) begin : g_slot
        logic [7:0] id_q;
        logic [7:0] pend_d;
        logic       pend_v;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                id_q   <= 8'h00;
                pend_d <= 8'h00;
                pend_v <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                if (bus_busy) begin
                    pend_d <= wr_data;
                    pend_v <= 1'b1;
                end else begin
                    id_q   <= wr_data;
                    pend_v <= 1'b0;
                end
            end else if (pend_v && !bus_busy) begin
                id_q   <= pend_d;
                pend_v <= 1'b0;
            end
        end

        assign hit_vec[g]         = (id_q[7:1] == addr_byte[7:1]);
        assign ids_flat[g*8 +: 8] = id_q;
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N_ID - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/i2c_quad_slave.sv
module i2c_quad_slave
    import i2c_qs_pkg::*;
#(
    parameter int N_ID        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(N_ID)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             id_wr_en,
    input  logic [IDX_W-1:0] id_wr_idx,
    input  logic [7:0]       id_wr_data,
    input  logic [7:0]       tx_data,
    output logic             match,
    output logic [IDX_W-1:0] match_idx,
    output logic [7:0]       rx_data,
    output logic             rx_valid
);
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt, bus_busy;
    logic hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [N_ID*8-1:0] ids_flat;

    sl_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       shreg;
    logic [7:0]       txsr;
    logic             dir_q;
    logic             nack_q;
    logic             byte_done;

    i2c_qs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .bus_busy(bus_busy)
    );

    i2c_qs_idbank #(.N_ID(N_ID), .IDX_W(IDX_W)) u_ids (
        .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy),
        .wr_en(id_wr_en), .wr_idx(id_wr_idx), .wr_data(id_wr_data),
        .addr_byte(shreg), .hit(hit), .hit_idx(hit_idx), .ids_flat(ids_flat)
    );

    assign byte_done = scl_fall && (cnt == LAST_BIT);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_evt) begin
            state_nx = SL_ADDR;
        end else if (stop_evt) begin
            state_nx = SL_IDLE;
        end else begin
            unique case (state)
                SL_IDLE, SL_IGNORE: state_nx = state;
                SL_ADDR:     if (byte_done) state_nx = hit ? SL_ADDR_ACK : SL_IGNORE;
                SL_ADDR_ACK: if (scl_fall)  state_nx = dir_q ? SL_TX : SL_RX;
                SL_RX:       if (byte_done) state_nx = SL_RX_ACK;
                SL_RX_ACK:   if (scl_fall)  state_nx = SL_RX;
                SL_TX:       if (byte_done) state_nx = SL_TX_ACK;
                SL_TX_ACK:   if (scl_fall)  state_nx = nack_q ? SL_IDLE : SL_TX;
                default:     state_nx = SL_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SL_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= 8'h00;
            txsr      <= 8'h00;
            dir_q     <= 1'b0;
            nack_q    <= 1'b0;
            sda_oe    <= 1'b0;
            match     <= 1'b0;
            match_idx <= '0;
            rx_data   <= 8'h00;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start_evt) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                match  <= 1'b0;
            end else if (stop_evt) begin
                sda_oe <= 1'b0;
                match  <= 1'b0;
            end else begin
                unique case (state)
                    SL_ADDR, SL_RX: begin
                        if (scl_rise && cnt < LAST_BIT) begin
                            shreg <= {shreg[6:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end
                        if (byte_done) begin
                            if (state == SL_RX) begin
                                rx_data  <= shreg;
                                rx_valid <= 1'b1;
                                sda_oe   <= 1'b1;
                            end else if (hit) begin
                                sda_oe    <= 1'b1;
                                match     <= 1'b1;
                                match_idx <= hit_idx;
                                dir_q     <= shreg[0];
                            end
                        end
                    end
                    SL_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (dir_q) begin
                                txsr   <= tx_data;
                                sda_oe <= ~tx_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    SL_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                        end
                    end
                    SL_TX: begin
                        if (scl_rise && cnt < LAST_BIT) cnt <= cnt + 1'b1;
                        if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                            end else if (cnt != '0) begin
                                txsr   <= {txsr[6:0], 1'b0};
                                sda_oe <= ~txsr[6];
                            end
                        end
                    end
                    SL_TX_ACK: begin
                        if (scl_rise) nack_q <= sda_lvl;
                        if (scl_fall) begin
                            if (nack_q) begin
                                match <= 1'b0;
                            end else begin
                                txsr   <= tx_data;
                                sda_oe <= ~tx_data[7];
                                cnt    <= '0;
                            end
                        end
                    end
                    SL_IDLE, SL_IGNORE: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_quad_slave_chk.sv
module i2c_quad_slave_chk #(
    parameter int N_ID  = 4,
    parameter int IDX_W = $clog2(N_ID)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              match,
    input logic [IDX_W-1:0]  match_idx,
    input logic              rx_valid,
    input logic              start_evt,
    input logic              bus_busy,
    input logic [N_ID*8-1:0] ids_flat
);
    a_r10_pull_only_when_matched: assert property (
        @(posedge clk) disable iff (!rst_n) sda_oe |-> match);

    a_r4_idx_holds: assert property (
        @(posedge clk) disable iff (!rst_n) (match && $past(match)) |-> $stable(match_idx));

    a_r6_rx_needs_match: assert property (
        @(posedge clk) disable iff (!rst_n) rx_valid |-> match);

    a_r11_start_restarts: assert property (
        @(posedge clk) disable iff (!rst_n) start_evt |=> (!match && !sda_oe));

    a_r9_ids_frozen_busy: assert property (
        @(posedge clk) disable iff (!rst_n) (bus_busy && $past(bus_busy)) |-> $stable(ids_flat));
endmodule

bind i2c_quad_slave i2c_quad_slave_chk #(.N_ID(N_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .match(match),
    .match_idx(match_idx), .rx_valid(rx_valid), .start_evt(start_evt),
    .bus_busy(bus_busy), .ids_flat(ids_flat)
);

// File: tb/i2c_quad_slave_test.sv
module i2c_quad_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic id_wr_en = 1'b0;
    logic [1:0] id_wr_idx = 2'd0;
    logic [7:0] id_wr_data = 8'h00;
    logic [7:0] tx_data = 8'h00;
    logic match;
    logic [1:0] match_idx;
    logic [7:0] rx_data;
    logic rx_valid;
    logic sda_bus;

    int errors = 0;
    int checks = 0;
    int rx_count = 0;
    logic [7:0] last_rx = 8'h00;
    logic ack_seen, m_seen;
    logic [1:0] idx_seen;
    logic [7:0] ids [4];
    bit done = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_quad_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .id_wr_en(id_wr_en), .id_wr_idx(id_wr_idx), .id_wr_data(id_wr_data),
        .tx_data(tx_data), .match(match), .match_idx(match_idx),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always @(posedge clk) if (rx_valid) begin
        rx_count <= rx_count + 1;
        last_rx  <= rx_data;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_id(input logic [1:0] idx, input logic [7:0] val);
        id_wr_idx = idx; id_wr_data = val; id_wr_en = 1'b1;
        wait_clk(1);
        id_wr_en = 1'b0;
        wait_clk(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(H);
            scl_m = 1'b1; wait_clk(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H/2);
        ack_seen = ~sda_bus;
        m_seen   = match;
        idx_seen = match_idx;
        wait_clk(H/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] d);
        d = 8'h00;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_clk(H);
            scl_m = 1'b1; wait_clk(H/2);
            d = {d[6:0], sda_bus};
            wait_clk(H/2);
            scl_m = 1'b0;
        end
    endtask

    task automatic master_ack(input logic give_ack);
        sda_m = ~give_ack; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        scl_m = 1'b0;
    endtask

    function automatic logic [2:0] expect_hit(input logic [6:0] a);
        for (int k = 0; k < 4; k++)
            if (ids[k][7:1] == a) return {1'b1, 2'(k)};
        return 3'b000;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [2:0] e;
        int rx_before;
        wait_clk(4);
        // R1 reset state
        check("R1 sda_oe", sda_oe, 0);
        check("R1 match", match, 0);
        check("R1 rx_valid", rx_valid, 0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 idx", match_idx, 0);

        // R9 idle writes take effect immediately; R3/R4 duplicate upper bits in 1 and 2
        ids[0] = 8'h52; ids[1] = 8'hA4; ids[2] = 8'hA5; ids[3] = 8'h10;
        for (int k = 0; k < 4; k++) write_id(2'(k), ids[k]);

        // R2 R3 R4 sweep every 7-bit address, write direction
        for (int a = 0; a < 128; a++) begin
            e = expect_hit(7'(a));
            bus_start();
            send_byte({7'(a), 1'b0});
            check($sformatf("R2 ack addr %02h", a), {ack_seen, m_seen}, {e[2], e[2]});
            if (e[2]) check($sformatf("R4 idx addr %02h", a), idx_seen, e[1:0]);
            bus_stop();
        end
        // R3: address with bit0 = 1 of an id whose stored bit0 = 0 still hits (read dir)
        bus_start();
        tx_data = 8'hFF;
        send_byte(8'h11);
        check("R3 bit0 ignored", {ack_seen, idx_seen}, {1'b1, 2'd3});
        recv_byte(d);
        master_ack(1'b0);
        bus_stop();

        // R5 miss then a byte equal to a valid id is not acknowledged
        rx_before = rx_count;
        bus_start();
        send_byte(8'h7E);
        check("R5 miss no ack", {ack_seen, m_seen}, 2'b00);
        send_byte(8'h52);
        check("R5 later byte ignored", {ack_seen, m_seen}, 2'b00);
        check("R5 no rx strobe", rx_count, rx_before);
        bus_stop();

        // R6 receive
        bus_start();
        send_byte(8'h52);
        check("R6 addr ack", {ack_seen, idx_seen}, {1'b1, 2'd0});
        send_byte(8'h3C);
        check("R6 ack b0", ack_seen, 1);
        check("R6 data b0", last_rx, 8'h3C);
        send_byte(8'hFF);
        check("R6 data b1", last_rx, 8'hFF);
        send_byte(8'h01);
        check("R6 data b2", {ack_seen, last_rx}, {1'b1, 8'h01});
        check("R6 strobe count", rx_count, rx_before + 3);
        bus_stop();

        // R7 transmit, R8 nack release
        tx_data = 8'hC3;
        bus_start();
        send_byte(8'h53);
        check("R7 addr ack", ack_seen, 1);
        recv_byte(d);
        check("R7 byte0", d, 8'hC3);
        tx_data = 8'h5A;
        master_ack(1'b1);
        recv_byte(d);
        check("R7 byte1", d, 8'h5A);
        master_ack(1'b0);
        wait_clk(H);
        check("R8 released", {sda_oe, match}, 2'b00);
        bus_stop();

        // R9 write held across a repeated START; R11 repeated start restarts address
        bus_start();
        send_byte(8'hA4);
        check("R11 first addr", {ack_seen, idx_seen}, {1'b1, 2'd1});
        write_id(2'd3, 8'h70);
        bus_start();
        check("R11 match cleared", match, 0);
        send_byte(8'h70);
        check("R9 held while busy", ack_seen, 0);
        bus_stop();
        wait_clk(4);
        bus_start();
        send_byte(8'h70);
        check("R9 applied after stop", {ack_seen, idx_seen}, {1'b1, 2'd3});
        bus_stop();
        check("R11 stop clears", {match, sda_oe}, 2'b00);
        bus_start();
        send_byte(8'h10);
        check("R9 old id gone", ack_seen, 0);
        bus_stop();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule